// File: doc/BRIEF.md
# Compressed Instruction Stream Aligner

This block sits between an instruction fetch buffer and an instruction decoder. Fetch words are 32 bits wide and always come from word-aligned addresses. The instruction stream inside them packs 16-bit compressed and 32-bit full-length RISC-V encodings back to back, with no padding. The aligner hands the decoder exactly one whole instruction per output handshake, with its program counter, its size and its status flags.

A fetch word may carry two compressed instructions. It may also carry one compressed instruction followed by the first half of a full-length instruction. In the second case the word is accepted without producing anything. Its upper halfword is kept in a holding register and later joined with the lower halfword of the next fetch word. A full-length instruction that crosses a word boundary therefore comes out as a single instruction.

A redirect input discards any held halfword and takes the next fetch word as the start of a new target. If that target lies at the upper halfword of its word, the lower halfword is dropped.

Top module: `cstream_aligner`

## Requirements
- R1: A full-length instruction that starts at the lower halfword of a fetch word is issued in one handshake. Its PC is the word address, and the fetch word is accepted in that same cycle.
- R2: An instruction whose two least significant bits are not 2'b11 is compressed. It is issued zero-extended to 32 bits, with `out_cmp` set to 1.
- R3: An instruction whose two least significant bits equal 2'b11 is full length. It is issued with `out_cmp` set to 0.
- R4: A fetch word that holds two compressed instructions gives two handshakes, with PCs at the word address and the word address plus 2. `in_ready` stays low during the first handshake and is high during the second.
- R5: A full-length instruction that starts in an upper halfword is issued once the next fetch word arrives. The first word is accepted with `out_valid` low. The issued instruction is {next word bits 15:0, held halfword}, and its PC is the first word address plus 2. The upper half of the next word is handled afterwards.
- R6: `out_err` is the OR of the error flags of every fetch word that contributed bits to the issued instruction.
- R7: `out_pred` carries the prediction flag of the fetch word that holds the first halfword of the issued instruction.
- R8: While `redirect` is high, no handshake happens on either side and any held halfword is discarded. When `redirect_half` is 1, the lower halfword of the next accepted fetch word is skipped.
- R9: While `out_ready` is low, no fetch word is accepted and the offered instruction does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redirect | input | 1 | Flush request for a new fetch target |
| redirect_half | input | 1 | New target starts at the upper halfword of its word |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Fetch word accepted |
| in_word | input | 32 | Fetch word |
| in_waddr | input | AW-2 | Fetch word address, bits AW-1:2 |
| in_pred | input | 1 | Prediction flag of the fetch word |
| in_err | input | 1 | Fetch error flag of the fetch word |
| out_valid | output | 1 | Instruction valid |
| out_ready | input | 1 | Decoder accepts the instruction |
| out_instr | output | 32 | Instruction; compressed ones zero-extended |
| out_pc | output | AW | Instruction address |
| out_cmp | output | 1 | Instruction is compressed |
| out_err | output | 1 | Fetch error on a contributing word |
| out_pred | output | 1 | Prediction flag of the first halfword's word |

## Verification
The hardest cases to reach from the ports are the straddling full-length instruction and a redirect that arrives while a halfword is held. Both need the lower halfword of one word to be used first, then a word to be accepted with no output, and only then the completing word or the redirect. The directed tasks build this sequence on purpose: a compressed lower half is issued first, then the stash cycle is observed, and then either the next word or the flush is applied. For the flush, the next word is chosen so that a halfword left in the holding register would give a visibly different instruction and PC.

// File: rtl/cstream_aligner.sv
module cstream_aligner #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic          redirect_half,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_word,
  input  logic [AW-3:0] in_waddr,
  input  logic          in_pred,
  input  logic          in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_instr,
  output logic [AW-1:0] out_pc,
  output logic          out_cmp,
  output logic          out_err,
  output logic          out_pred
);
  logic          hold_v, skip_lo, hold_err, hold_pred;
  logic [15:0]   hold_hw;
  logic [AW-3:0] hold_wa;

  wire [15:0] lo = in_word[15:0];
  wire [15:0] hi = in_word[31:16];
  wire lo_full = (lo[1:0] == 2'b11);
  wire hi_full = (hi[1:0] == 2'b11);
  wire stash   = !hold_v && skip_lo && hi_full;
  wire take    = out_valid && out_ready;

  assign out_valid = in_valid && !redirect && !stash;
  assign in_ready  = in_valid && !redirect &&
                     (stash || (out_ready && !hold_v && (skip_lo || lo_full)));

  always_comb begin
    if (hold_v) begin
      out_instr = {lo, hold_hw};
      out_pc    = {hold_wa, 2'b10};
      out_cmp   = 1'b0;
      out_err   = hold_err | in_err;
      out_pred  = hold_pred;
    end else if (skip_lo) begin
      out_instr = {16'h0000, hi};
      out_pc    = {in_waddr, 2'b10};
      out_cmp   = 1'b1;
      out_err   = in_err;
      out_pred  = in_pred;
    end else begin
      out_instr = lo_full ? in_word : {16'h0000, lo};
      out_pc    = {in_waddr, 2'b00};
      out_cmp   = !lo_full;
      out_err   = in_err;
      out_pred  = in_pred;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      skip_lo   <= 1'b0;
      hold_hw   <= '0;
      hold_wa   <= '0;
      hold_err  <= 1'b0;
      hold_pred <= 1'b0;
    end else if (redirect) begin
      hold_v  <= 1'b0;
      skip_lo <= redirect_half;
    end else if (hold_v) begin
      if (take) begin
        hold_v  <= 1'b0;
        skip_lo <= 1'b1;
      end
    end else if (stash && in_valid) begin
      hold_v    <= 1'b1;
      hold_hw   <= hi;
      hold_wa   <= in_waddr;
      hold_err  <= in_err;
      hold_pred <= in_pred;
      skip_lo   <= 1'b0;
    end else if (take) begin
      skip_lo <= !skip_lo && !lo_full;
    end
  end
endmodule

// File: rtl/cstream_aligner_chk.sv
module cstream_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        redirect,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_instr,
  input logic        out_cmp,
  input logic        hold_v
);
  a_r1_out_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
  a_r2_cmp_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cmp) |-> (out_instr[31:16] == 16'h0000 && out_instr[1:0] != 2'b11));
  a_r3_full_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_cmp) |-> (out_instr[1:0] == 2'b11));
  a_r5_stash_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid) |=> hold_v);
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !hold_v);
  a_r8_flush_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!out_valid && !in_ready));
  a_r9_stall_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind cstream_aligner cstream_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .redirect(redirect), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_instr(out_instr), .out_cmp(out_cmp), .hold_v(hold_v)
);

// File: tb/tb_cstream_aligner.sv
`timescale 1ns/1ps
module tb_cstream_aligner;
  logic clk = 1'b0, rst_n = 1'b0;
  logic redirect = 1'b0, redirect_half = 1'b0;
  logic in_valid = 1'b0, in_ready, in_pred = 1'b0, in_err = 1'b0;
  logic [31:0] in_word = '0;
  logic [29:0] in_waddr = '0;
  logic out_valid, out_ready = 1'b1, out_cmp, out_err, out_pred;
  logic [31:0] out_instr, out_pc;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cstream_aligner dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] w, input logic p, input logic e);
    in_valid = 1'b1; in_waddr = a[31:2]; in_word = w; in_pred = p; in_err = e; #0.5;
  endtask

  task automatic expect_instr(input string req, input logic [31:0] ins, input logic [31:0] pc,
                              input logic c, input logic e, input logic p, input logic fr);
    chk(req, "out_valid", {31'b0, out_valid}, 32'd1);
    chk(req, "out_instr", out_instr, ins);
    chk(req, "out_pc", out_pc, pc);
    chk(req, "out_cmp", {31'b0, out_cmp}, {31'b0, c});
    chk(req, "out_err", {31'b0, out_err}, {31'b0, e});
    chk(req, "out_pred", {31'b0, out_pred}, {31'b0, p});
    chk(req, "in_ready", {31'b0, in_ready}, {31'b0, fr});
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    #0.5;
    chk("R1", "reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1", "reset in_ready", {31'b0, in_ready}, 32'd0);
  endtask

  task automatic t_full_aligned();
    drive(32'h0, 32'h00A00093, 1'b0, 1'b0);
    expect_instr("R1 R3", 32'h00A00093, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_two_compressed();
    drive(32'h4, 32'h45854505, 1'b0, 1'b1);
    expect_instr("R2 R4 R6", 32'h00004505, 32'h4, 1'b1, 1'b1, 1'b0, 1'b0);
    step(); #0.5;
    expect_instr("R2 R4", 32'h00004585, 32'h6, 1'b1, 1'b1, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_straddle();
    drive(32'h8, 32'h00930001, 1'b1, 1'b0);
    expect_instr("R5 R7", 32'h00000001, 32'h8, 1'b1, 1'b0, 1'b1, 1'b0);
    step(); #0.5;
    chk("R5", "stash out_valid", {31'b0, out_valid}, 32'd0);
    chk("R5", "stash in_ready", {31'b0, in_ready}, 32'd1);
    step();
    drive(32'hC, 32'h450500A0, 1'b0, 1'b1);
    expect_instr("R5 R6 R7", 32'h00A00093, 32'hA, 1'b0, 1'b1, 1'b1, 1'b0);
    step(); #0.5;
    expect_instr("R5 R7", 32'h00004505, 32'hE, 1'b1, 1'b1, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    drive(32'h10, 32'h45854505, 1'b0, 1'b0);
    expect_instr("R9", 32'h00004505, 32'h10, 1'b1, 1'b0, 1'b0, 1'b0);
    step(); #0.5;
    expect_instr("R9", 32'h00004505, 32'h10, 1'b1, 1'b0, 1'b0, 1'b0);
    out_ready = 1'b1; step(); #0.5;
    expect_instr("R9 R4", 32'h00004585, 32'h12, 1'b1, 1'b0, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_redirect();
    drive(32'h20, 32'h00930001, 1'b0, 1'b0);
    step(); step();
    redirect = 1'b1; redirect_half = 1'b1; in_valid = 1'b0; #0.5;
    chk("R8", "flush out_valid", {31'b0, out_valid}, 32'd0);
    chk("R8", "flush in_ready", {31'b0, in_ready}, 32'd0);
    step();
    redirect = 1'b0; redirect_half = 1'b0;
    drive(32'h40, 32'h4505FFFF, 1'b0, 1'b0);
    expect_instr("R8", 32'h00004505, 32'h42, 1'b1, 1'b0, 1'b0, 1'b1);
    step();
    redirect = 1'b1;
    drive(32'h60, 32'h12345678, 1'b0, 1'b0);
    chk("R8", "flush with word in_ready", {31'b0, in_ready}, 32'd0);
    step();
    redirect = 1'b0;
    drive(32'h80, 32'h00A00093, 1'b0, 1'b0);
    expect_instr("R8 R1", 32'h00A00093, 32'h80, 1'b0, 1'b0, 1'b0, 1'b1);
    step();
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_aligned();
    t_two_compressed();
    t_straddle();
    t_backpressure();
    t_redirect();
    finish_up();
  end
endmodule